// File: doc/BRIEF.md
# Configuration Header Register File

This block holds the 256-byte configuration header of a single bus function and serves it through a one-cycle request port. Each request carries a byte offset, a length code (1, 2 or 4 bytes) and, for writes, a little-endian data word. Reads return their data one cycle later, together with a one-cycle valid pulse. Writes have no response.

Every write goes through a per-byte protection map. The map is chosen by the header type byte held at offset 0x0E, which selects between the endpoint layout and the bridge layout. A full aligned dword write to a base address slot that was given a non-zero size at elaboration takes a separate path. That path clears the address bits below the size and forces the slot's type bits, or in the case of the expansion ROM slot, keeps the enable bit. The reserved high bits of the command word are cleared before they are stored.

After any write that can move an address window, the block raises a single-cycle strobe, so that a downstream address decoder knows to re-evaluate its windows.

Top module: `cfg_space`

## Requirements
- R1: After reset, offsets 0x00–0x03 hold the vendor and device identifiers, 0x08 the revision, 0x09–0x0B the class code, 0x0E the header type, 0x2C–0x2F the subsystem identifiers and 0x3D the interrupt pin, all set by parameters. A sized base address slot at 0x10+4*k reads its type bits. Every other byte reads zero.
- R2: A read accepted at a clock edge drives rdata_o and a single-cycle rvalid_o high at the next edge. Byte offset+k appears in rdata_o bits 8k+7:8k, and any byte above the access width reads zero. A write never raises rvalid_o.
- R3: A 4-byte read at an offset above 0xFC is served as a 2-byte read. A 2-byte read at an offset above 0xFE, including one that comes from that first narrowing, is served as a 1-byte read.
- R4: A write on the byte path updates ascending offsets from addr_i and stops after offset 0xFF. Nothing wraps to offset 0x00.
- R5: With header type 0x00 or 0x80, the byte path leaves these offsets unchanged: 0x00–0x03, 0x06–0x0B, 0x0E, 0x10–0x27, 0x2C–0x33 and 0x3D.
- R6: With any other header type, the byte path leaves 0x00–0x03, 0x06–0x0B, 0x0E, 0x2C–0x2F, 0x38–0x3B and 0x3D unchanged. The offsets 0x10–0x27 and 0x30–0x33 can then be written byte by byte.
- R7: A write with length code 4 at a dword-aligned offset 0x10+4*k, where slot k has a non-zero size S, stores (data & ~(S-1)) | type_k, whatever the header type.
- R8: The same kind of write at offset 0x30 with a non-zero ROM size S stores (data & ~(S-1)) | (data & 1).
- R9: A dword write to an unsized slot, or an unaligned dword write, takes the byte path instead of the slot path.
- R10: Bits set in parameter CMD_HI_RSVD are cleared from any byte written to offset 0x05.
- R11: map_upd_o pulses for one cycle, one edge after a write that covers offset 0x04 or 0x05 or that takes the slot path of R7/R8. It stays low after reads and after all other writes.
- R12: The length code len_i is 1 for a single byte and 2 for a word. Every other code, 0 and 3 included, means 4 bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Request valid for one cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 8 | Byte offset |
| len_i | input | 3 | Length code (see R12) |
| wdata_i | input | 32 | Write data, little-endian |
| rvalid_o | output | 1 | Read data valid pulse |
| rdata_o | output | 32 | Read data, little-endian |
| map_upd_o | output | 1 | Address-map refresh strobe |

## Verification
The hardest case to reach is the dependence on the header type. Offset 0x0E can never be written, so one instance cannot show both protection maps. The bench therefore builds a second instance with the bridge header type and a different slot sizing, then writes the same offsets on both and compares what each kept. The top-of-space edge cases need data planted at 0xFC–0xFF before the narrowed reads and the clipped writes can be told apart, so those tests first fill that dword with a known pattern.

// File: rtl/cfg_space_pkg.sv
package cfg_space_pkg;

  localparam int unsigned NUM_SLOTS = 6;
  localparam logic [7:0]  SLOT_BASE = 8'h10;
  localparam logic [7:0]  ROM_OFS   = 8'h30;
  localparam logic [7:0]  HDR_OFS   = 8'h0E;

  function automatic logic [2:0] len_bytes(input logic [2:0] len);
    case (len)
      3'd1:    return 3'd1;
      3'd2:    return 3'd2;
      default: return 3'd4;
    endcase
  endfunction

  function automatic logic ro_endpoint(input logic [7:0] a);
    return (a <= 8'h03) || (a >= 8'h06 && a <= 8'h0B) || (a == 8'h0E) ||
           (a >= 8'h10 && a <= 8'h27) || (a >= 8'h2C && a <= 8'h33) ||
           (a == 8'h3D);
  endfunction

  function automatic logic ro_bridge(input logic [7:0] a);
    return (a <= 8'h03) || (a >= 8'h06 && a <= 8'h0B) || (a == 8'h0E) ||
           (a >= 8'h2C && a <= 8'h2F) || (a >= 8'h38 && a <= 8'h3B) ||
           (a == 8'h3D);
  endfunction

endpackage

// File: rtl/cfg_wr_protect.sv
module cfg_wr_protect
  import cfg_space_pkg::*;
#(
  parameter int unsigned NBYTES = 256
) (
  input  logic [7:0]        hdr_i,
  output logic [NBYTES-1:0] wr_ok_o
);
  logic endpoint;
  assign endpoint = (hdr_i == 8'h00) || (hdr_i == 8'h80);

  for (genvar b = 0; b < NBYTES; b++) begin : g_byte
    localparam logic [7:0] OFS = 8'(b);
    assign wr_ok_o[b] = endpoint ? !ro_endpoint(OFS) : !ro_bridge(OFS);
  end

  always_comb begin
    assert (!wr_ok_o[HDR_OFS]) else $error("assert_hdr_ro_R5");
  end
endmodule

// File: rtl/cfg_slot_path.sv
module cfg_slot_path
  import cfg_space_pkg::*;
#(
  parameter logic [NUM_SLOTS-1:0][31:0] SLOT_SIZE = '0,
  parameter logic [NUM_SLOTS-1:0][31:0] SLOT_TYPE = '0,
  parameter logic [31:0]                ROM_SIZE  = '0
) (
  input  logic        wr_i,
  input  logic [7:0]  addr_i,
  input  logic [2:0]  nb_i,
  input  logic [31:0] wdata_i,
  output logic        hit_o,
  output logic [7:0]  base_o,
  output logic [31:0] val_o
);
  logic dword_al;
  assign dword_al = wr_i && (nb_i == 3'd4) && (addr_i[1:0] == 2'b00);

  always_comb begin
    hit_o  = 1'b0;
    base_o = addr_i;
    val_o  = '0;
    for (int k = 0; k < NUM_SLOTS; k++) begin
      if (dword_al && SLOT_SIZE[k] != 0 && addr_i == SLOT_BASE + 8'(4 * k)) begin
        hit_o = 1'b1;
        val_o = (wdata_i & ~(SLOT_SIZE[k] - 32'd1)) | SLOT_TYPE[k];
      end
    end
    if (dword_al && ROM_SIZE != 0 && addr_i == ROM_OFS) begin
      hit_o = 1'b1;
      val_o = (wdata_i & ~(ROM_SIZE - 32'd1)) | {31'd0, wdata_i[0]};
    end
  end
endmodule

// File: rtl/cfg_rd_port.sv
module cfg_rd_port #(
  parameter int unsigned NBYTES = 256
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                rd_i,
  input  logic [7:0]          addr_i,
  input  logic [2:0]          nb_i,
  input  logic [8*NBYTES-1:0] cfg_i,
  output logic                rvalid_o,
  output logic [31:0]         rdata_o
);
  logic [2:0]  eff;
  logic [31:0] gath;

  always_comb begin
    eff = nb_i;
    if (eff == 3'd4 && addr_i > 8'hFC) eff = 3'd2;
    if (eff == 3'd2 && addr_i > 8'hFE) eff = 3'd1;
    gath = '0;
    for (int k = 0; k < 4; k++) begin
      if (3'(k) < eff) gath[8*k +: 8] = cfg_i[{addr_i + 8'(k), 3'b000} +: 8];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rvalid_o <= 1'b0;
      rdata_o  <= '0;
    end else begin
      rvalid_o <= rd_i;
      if (rd_i) rdata_o <= gath;
    end
  end

  assert_rvalid_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i |=> rvalid_o);
  assert_rvalid_low_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> !rvalid_o);
  assert_byte_upper_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && addr_i == 8'hFF) |=> (rdata_o[31:8] == 24'd0));
endmodule

// File: rtl/cfg_space.sv
module cfg_space
  import cfg_space_pkg::*;
#(
  parameter logic [15:0] VENDOR_ID   = 16'h5A17,
  parameter logic [15:0] DEVICE_ID   = 16'h0C3E,
  parameter logic [7:0]  REVISION    = 8'h02,
  parameter logic [23:0] CLASS_CODE  = 24'h020000,
  parameter logic [7:0]  HDR_TYPE    = 8'h00,
  parameter logic [15:0] SUB_VENDOR  = 16'h5A17,
  parameter logic [15:0] SUB_ID      = 16'h0001,
  parameter logic [7:0]  INT_PIN     = 8'h01,
  parameter logic [7:0]  CMD_HI_RSVD = 8'hF8,
  parameter logic [NUM_SLOTS-1:0][31:0] SLOT_SIZE =
    {32'h0, 32'h0, 32'h0, 32'h0, 32'h20, 32'h1000},
  parameter logic [NUM_SLOTS-1:0][31:0] SLOT_TYPE =
    {32'h0, 32'h0, 32'h0, 32'h0, 32'h1, 32'h8},
  parameter logic [31:0] ROM_SIZE    = 32'h800
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        req_i,
  input  logic        we_i,
  input  logic [7:0]  addr_i,
  input  logic [2:0]  len_i,
  input  logic [31:0] wdata_i,
  output logic        rvalid_o,
  output logic [31:0] rdata_o,
  output logic        map_upd_o
);
  localparam int unsigned NBYTES = 256;

  function automatic logic [7:0] rst_byte(input int b);
    logic [7:0] v;
    v = 8'h00;
    case (b)
      'h00: v = VENDOR_ID[7:0];
      'h01: v = VENDOR_ID[15:8];
      'h02: v = DEVICE_ID[7:0];
      'h03: v = DEVICE_ID[15:8];
      'h08: v = REVISION;
      'h09: v = CLASS_CODE[7:0];
      'h0A: v = CLASS_CODE[15:8];
      'h0B: v = CLASS_CODE[23:16];
      'h0E: v = HDR_TYPE;
      'h2C: v = SUB_VENDOR[7:0];
      'h2D: v = SUB_VENDOR[15:8];
      'h2E: v = SUB_ID[7:0];
      'h2F: v = SUB_ID[15:8];
      'h3D: v = INT_PIN;
      default: v = 8'h00;
    endcase
    for (int k = 0; k < NUM_SLOTS; k++) begin
      if (SLOT_SIZE[k] != 0 && b >= 'h10 + 4*k && b < 'h14 + 4*k)
        v = SLOT_TYPE[k][8*(b - 'h10 - 4*k) +: 8];
    end
    return v;
  endfunction

  logic [7:0]          cfg_q [NBYTES];
  logic [8*NBYTES-1:0] cfg_flat;
  logic [NBYTES-1:0]   wr_ok;
  logic [2:0]          nb;
  logic                wr, rd;
  logic [8:0]          end9;
  logic                slot_hit;
  logic [7:0]          slot_base;
  logic [31:0]         slot_val;
  logic                cmd_touch;

  assign nb   = len_bytes(len_i);
  assign wr   = req_i && we_i;
  assign rd   = req_i && !we_i;
  assign end9 = {1'b0, addr_i} + {6'd0, nb};

  cfg_wr_protect #(.NBYTES(NBYTES)) u_protect (
    .hdr_i   (cfg_q[HDR_OFS]),
    .wr_ok_o (wr_ok)
  );

  cfg_slot_path #(
    .SLOT_SIZE(SLOT_SIZE),
    .SLOT_TYPE(SLOT_TYPE),
    .ROM_SIZE (ROM_SIZE)
  ) u_slot (
    .wr_i    (wr),
    .addr_i  (addr_i),
    .nb_i    (nb),
    .wdata_i (wdata_i),
    .hit_o   (slot_hit),
    .base_o  (slot_base),
    .val_o   (slot_val)
  );

  for (genvar b = 0; b < NBYTES; b++) begin : g_cfg
    localparam logic [8:0] B9  = 9'(b);
    localparam logic [7:0] RST = rst_byte(b);
    localparam logic [7:0] KEEP = (b == 5) ? ~CMD_HI_RSVD : 8'hFF;
    logic       in_win, in_slot;
    logic [1:0] lane, slane;

    assign lane    = 2'(B9 - {1'b0, addr_i});
    assign slane   = 2'(B9 - {1'b0, slot_base});
    assign in_win  = (B9 >= {1'b0, addr_i}) && (B9 < end9);
    assign in_slot = (B9 >= {1'b0, slot_base}) && (B9 < {1'b0, slot_base} + 9'd4);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        cfg_q[b] <= RST;
      end else if (slot_hit) begin
        if (in_slot) cfg_q[b] <= slot_val[8*slane +: 8];
      end else if (wr && in_win && wr_ok[b]) begin
        cfg_q[b] <= wdata_i[8*lane +: 8] & KEEP;
      end
    end
    assign cfg_flat[8*b +: 8] = cfg_q[b];
  end

  cfg_rd_port #(.NBYTES(NBYTES)) u_rd (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .rd_i     (rd),
    .addr_i   (addr_i),
    .nb_i     (nb),
    .cfg_i    (cfg_flat),
    .rvalid_o (rvalid_o),
    .rdata_o  (rdata_o)
  );

  // command word occupies 0x04..0x05
  assign cmd_touch = (addr_i <= 8'h05) && (end9 > 9'h004);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) map_upd_o <= 1'b0;
    else         map_upd_o <= wr && (cmd_touch || slot_hit);
  end

  assert_upd_src_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    map_upd_o |-> $past(req_i && we_i));
  assert_upd_pulse_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (map_upd_o && !$past(req_i && we_i, 2)) |=> !map_upd_o || $past(req_i && we_i));
  assert_hdr_stable_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $stable(cfg_q[HDR_OFS]));
  assert_cmd_rsvd_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_q[5] & CMD_HI_RSVD) == 8'h00);
  assert_id_stable_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $stable(cfg_q[0]) && $stable(cfg_q[3]));

  for (genvar k = 0; k < NUM_SLOTS; k++) begin : g_chk
    localparam int unsigned O = 'h10 + 4*k;
    if (SLOT_SIZE[k] > 1) begin : g_sized
      logic [31:0] word;
      assign word = {cfg_q[O+3], cfg_q[O+2], cfg_q[O+1], cfg_q[O]};
      assert_slot_type_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((word & (SLOT_SIZE[k] - 32'd1)) == (SLOT_TYPE[k] & (SLOT_SIZE[k] - 32'd1))));
    end
  end
endmodule

// File: tb/cfg_space_tb.sv
module cfg_space_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_a = 1'b0, req_b = 1'b0, we = 1'b0;
  logic [7:0]  addr = '0;
  logic [2:0]  len = 3'd4;
  logic [31:0] wdata = '0;
  logic        rv_a, rv_b, up_a, up_b;
  logic [31:0] rd_a, rd_b;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  cfg_space u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req_a), .we_i(we), .addr_i(addr),
    .len_i(len), .wdata_i(wdata), .rvalid_o(rv_a), .rdata_o(rd_a), .map_upd_o(up_a)
  );

  cfg_space #(
    .HDR_TYPE (8'h01),
    .SLOT_SIZE({32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h100}),
    .SLOT_TYPE('0),
    .ROM_SIZE (32'h0)
  ) u_dut_br (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req_b), .we_i(we), .addr_i(addr),
    .len_i(len), .wdata_i(wdata), .rvalid_o(rv_b), .rdata_o(rd_b), .map_upd_o(up_b)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic rd(input bit br, input logic [7:0] a, input logic [2:0] l,
                    output logic [31:0] d, output logic v);
    @(negedge clk);
    we = 1'b0; addr = a; len = l;
    if (br) req_b = 1'b1; else req_a = 1'b1;
    @(negedge clk);
    req_a = 1'b0; req_b = 1'b0;
    d = br ? rd_b : rd_a;
    v = br ? rv_b : rv_a;
  endtask

  task automatic wr(input bit br, input logic [7:0] a, input logic [2:0] l,
                    input logic [31:0] d, output logic u, output logic v);
    @(negedge clk);
    we = 1'b1; addr = a; len = l; wdata = d;
    if (br) req_b = 1'b1; else req_a = 1'b1;
    @(negedge clk);
    req_a = 1'b0; req_b = 1'b0; we = 1'b0;
    u = br ? up_b : up_a;
    v = br ? rv_b : rv_a;
  endtask

  function automatic logic [31:0] rd_val(input bit br, input logic [7:0] a, input logic [2:0] l);
    return 32'h0;
  endfunction

  logic [31:0] d;
  logic v, u;

  task automatic t_reset;
    rd(0, 8'h00, 3'd4, d, v); chk("R1 ids", d, 32'h0C3E_5A17);
    rd(0, 8'h08, 3'd4, d, v); chk("R1 class/rev", d, 32'h0200_0002);
    rd(0, 8'h0C, 3'd4, d, v); chk("R1 hdr type0", d, 32'h0);
    rd(0, 8'h10, 3'd4, d, v); chk("R1 slot0 type", d, 32'h8);
    rd(0, 8'h14, 3'd4, d, v); chk("R1 slot1 type", d, 32'h1);
    rd(0, 8'h2C, 3'd4, d, v); chk("R1 subsys", d, 32'h0001_5A17);
    rd(0, 8'h3C, 3'd4, d, v); chk("R1 int pin", d, 32'h0000_0100);
    rd(0, 8'h40, 3'd4, d, v); chk("R1 zero", d, 32'h0);
    rd(1, 8'h0C, 3'd4, d, v); chk("R1 hdr type1", d, 32'h0001_0000);
  endtask

  task automatic t_read_basic;
    @(negedge clk); chk("R2 idle rvalid", {31'd0, rv_a}, 32'd0);
    rd(0, 8'h00, 3'd4, d, v); chk("R2 rvalid", {31'd0, v}, 32'd1);
    @(negedge clk); chk("R2 rvalid one cycle", {31'd0, rv_a}, 32'd0);
    rd(0, 8'h01, 3'd2, d, v); chk("R2 word lanes", d, 32'h0000_3E5A);
    rd(0, 8'h02, 3'd1, d, v); chk("R2 byte lane", d, 32'h0000_003E);
    wr(0, 8'h3C, 3'd1, 32'hFFFF_FFA5, u, v); chk("R2 no rvalid on write", {31'd0, v}, 32'd0);
  endtask

  task automatic t_len;
    rd(0, 8'h00, 3'd3, d, v); chk("R12 len3 is dword", d, 32'h0C3E_5A17);
    rd(0, 8'h00, 3'd0, d, v); chk("R12 len0 is dword", d, 32'h0C3E_5A17);
    rd(0, 8'h00, 3'd2, d, v); chk("R12 len2 word", d, 32'h0000_5A17);
  endtask

  task automatic t_narrow;
    wr(0, 8'hFC, 3'd4, 32'hDDCC_BBAA, u, v);
    rd(0, 8'hFC, 3'd4, d, v); chk("R3 full at FC", d, 32'hDDCC_BBAA);
    rd(0, 8'hFD, 3'd4, d, v); chk("R3 dword at FD narrows", d, 32'h0000_CCBB);
    rd(0, 8'hFE, 3'd4, d, v); chk("R3 dword at FE narrows", d, 32'h0000_DDCC);
    rd(0, 8'hFF, 3'd4, d, v); chk("R3 dword at FF to byte", d, 32'h0000_00DD);
    rd(0, 8'hFF, 3'd2, d, v); chk("R3 word at FF to byte", d, 32'h0000_00DD);
  endtask

  task automatic t_stop;
    wr(0, 8'hFE, 3'd4, 32'h1122_3344, u, v);
    rd(0, 8'hFC, 3'd4, d, v); chk("R4 clipped write", d, 32'h3344_BBAA);
    rd(0, 8'h00, 3'd4, d, v); chk("R4 no wrap", d, 32'h0C3E_5A17);
    wr(0, 8'h41, 3'd4, 32'h8877_6655, u, v);
    rd(0, 8'h40, 3'd4, d, v); chk("R4 ascending lanes", d, 32'h7766_5500);
    rd(0, 8'h44, 3'd1, d, v); chk("R4 last lane", d, 32'h0000_0088);
  endtask

  task automatic t_prot_ep;
    wr(0, 8'h0C, 3'd4, 32'hFFFF_FFFF, u, v);
    rd(0, 8'h0C, 3'd4, d, v); chk("R5 hdr byte kept", d, 32'hFF00_FFFF);
    wr(0, 8'h3C, 3'd2, 32'hFFFF_FFFF, u, v);
    rd(0, 8'h3C, 3'd2, d, v); chk("R5 int pin kept", d, 32'h0000_01FF);
    wr(0, 8'h2C, 3'd4, 32'h1234_5678, u, v);
    rd(0, 8'h2C, 3'd4, d, v); chk("R5 subsys kept", d, 32'h0001_5A17);
    wr(0, 8'h30, 3'd1, 32'h0000_00FF, u, v);
    rd(0, 8'h30, 3'd4, d, v); chk("R5 rom byte kept", d, 32'h0);
    wr(0, 8'h34, 3'd4, 32'hA1B2_C3D4, u, v);
    rd(0, 8'h34, 3'd4, d, v); chk("R5 34 writable", d, 32'hA1B2_C3D4);
  endtask

  task automatic t_prot_br;
    wr(1, 8'h14, 3'd4, 32'hCAFE_BABE, u, v);
    rd(1, 8'h14, 3'd4, d, v); chk("R6 unsized slot bytes writable", d, 32'hCAFE_BABE);
    wr(1, 8'h30, 3'd4, 32'h1357_9BDF, u, v);
    rd(1, 8'h30, 3'd4, d, v); chk("R6 30 writable", d, 32'h1357_9BDF);
    wr(1, 8'h38, 3'd4, 32'hFFFF_FFFF, u, v);
    rd(1, 8'h38, 3'd4, d, v); chk("R6 38 kept", d, 32'h0);
    wr(1, 8'h0C, 3'd4, 32'hFFFF_FFFF, u, v);
    rd(1, 8'h0C, 3'd4, d, v); chk("R6 hdr kept", d, 32'hFF01_FFFF);
    wr(1, 8'h10, 3'd4, 32'hFFFF_FFFF, u, v);
    rd(1, 8'h10, 3'd4, d, v); chk("R7 bridge slot masked", d, 32'hFFFF_FF00);
  endtask

  task automatic t_slots;
    wr(0, 8'h10, 3'd4, 32'hFFFF_FFFF, u, v);
    chk("R11 upd on slot write", {31'd0, u}, 32'd1);
    rd(0, 8'h10, 3'd4, d, v); chk("R7 slot0 all ones", d, 32'hFFFF_F008);
    wr(0, 8'h10, 3'd4, 32'h1234_5677, u, v);
    rd(0, 8'h10, 3'd4, d, v); chk("R7 slot0 value", d, 32'h1234_5008);
    wr(0, 8'h14, 3'd4, 32'hFFFF_FFFF, u, v);
    rd(0, 8'h14, 3'd4, d, v); chk("R7 slot1 io", d, 32'hFFFF_FFE1);
    wr(0, 8'h30, 3'd4, 32'hABCD_E7FF, u, v);
    rd(0, 8'h30, 3'd4, d, v); chk("R8 rom enable kept", d, 32'hABCD_E001);
    wr(0, 8'h30, 3'd4, 32'hABCD_E7FE, u, v);
    rd(0, 8'h30, 3'd4, d, v); chk("R8 rom enable clear", d, 32'hABCD_E000);
  endtask

  task automatic t_unsized;
    wr(0, 8'h18, 3'd4, 32'hFFFF_FFFF, u, v);
    chk("R9 no upd unsized", {31'd0, u}, 32'd0);
    rd(0, 8'h18, 3'd4, d, v); chk("R9 unsized slot byte path", d, 32'h0);
    wr(0, 8'h12, 3'd4, 32'hFFFF_FFFF, u, v);
    rd(0, 8'h10, 3'd4, d, v); chk("R9 unaligned slot0 kept", d, 32'h1234_5008);
    wr(0, 8'h10, 3'd2, 32'hFFFF_FFFF, u, v);
    rd(0, 8'h10, 3'd4, d, v); chk("R9 word write slot0 kept", d, 32'h1234_5008);
  endtask

  task automatic t_cmd;
    wr(0, 8'h04, 3'd2, 32'h0000_FFFF, u, v);
    chk("R11 upd on cmd", {31'd0, u}, 32'd1);
    rd(0, 8'h04, 3'd2, d, v); chk("R10 cmd rsvd cleared", d, 32'h0000_07FF);
    wr(0, 8'h05, 3'd1, 32'h0000_00A9, u, v);
    chk("R11 upd on cmd hi", {31'd0, u}, 32'd1);
    rd(0, 8'h04, 3'd4, d, v); chk("R10 cmd hi masked", d, 32'h0000_01FF);
    wr(0, 8'h03, 3'd2, 32'h0000_0000, u, v);
    chk("R11 upd when crossing into cmd", {31'd0, u}, 32'd1);
    rd(0, 8'h04, 3'd1, d, v); chk("R11 cross wrote 04", d, 32'h0);
  endtask

  task automatic t_upd;
    wr(0, 8'h3C, 3'd1, 32'h0000_0011, u, v);
    chk("R11 no upd other", {31'd0, u}, 32'd0);
    wr(0, 8'h06, 3'd2, 32'h0000_FFFF, u, v);
    chk("R11 no upd status", {31'd0, u}, 32'd0);
    rd(0, 8'h04, 3'd4, d, v);
    chk("R11 no upd on read", {31'd0, up_a}, 32'd0);
    wr(0, 8'h10, 3'd4, 32'h0, u, v);
    @(negedge clk); chk("R11 single pulse", {31'd0, up_a}, 32'd0);
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_read_basic;
    t_len;
    t_narrow;
    t_stop;
    t_prot_ep;
    t_prot_br;
    t_slots;
    t_unsized;
    t_cmd;
    t_upd;
    repeat (2) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule